// File: doc/BRIEF.md
# Concurrent Write Conflict Resolver

This block sits in front of a small shared register-file memory that several processor ports write in the same clock cycle. Every port offers a valid bit, a word address and a data word. When two or more valid ports name the same word, a selectable policy decides what, if anything, lands in that word. A port whose write was taken gets a success flag and a port whose write was refused gets a fail flag. Ports that name different words never interfere, and each distinct word receives at most one commit per cycle.

There are four policies. The agree policy writes only when all clashing ports offer one value. The rotate policy lets one clashing port through, chosen by a turn pointer that moves on after each clash. The rank policy lets the lowest-numbered port through. The add policy writes the wrapped sum of every clashing value. Read ports are independent of the writers, need no arbitration and return the stored word in the same cycle.

Top module: `wcr_resolver`

## Requirements
- R1: While reset is asserted and directly after it, every memory word reads 0 and all success and fail flags are 0.
- R2: Each read port p returns in the same cycle the word at the address on bits [p*AW +: AW] of `rd_addr`, on bits [p*DW +: DW] of `rd_data`; any number of read ports may name the same word.
- R3: Success and fail flags for a request appear on the clock edge after it and are never both set for one port; a port that did not request has both flags at 0; a read in the cycle after a request returns the newly committed value.
- R4: Valid writes to distinct addresses in one cycle are all committed and all flagged as succeeding, and no word takes two commits in one cycle.
- R5: Agree policy (`mode` = 0): the clashing writes commit only if every clashing port offers the same value; otherwise all of them fail and the word keeps its old value.
- R6: Rotate policy (`mode` = 1): a turn pointer starts at 0 after reset; within a clash group the first valid port found scanning upward from the pointer (wrapping past the last port) succeeds and the rest fail; the pointer steps by one, wrapping, after every cycle in this mode that has any clash.
- R7: Rank policy (`mode` = 2): within a clash group the lowest-numbered port succeeds and the others fail.
- R8: Add policy (`mode` = 3): the word receives the sum modulo 2^DW of all clashing values and every clashing port succeeds.
- R9: A port whose valid bit is 0 changes no memory word and takes no part in any clash, whatever its address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Policy: 0 agree, 1 rotate, 2 rank, 3 add |
| wr_vld | input | NPORT | Write valid, one bit per port |
| wr_addr | input | NPORT*AW | Write addresses, port p at [p*AW +: AW] |
| wr_data | input | NPORT*DW | Write data, port p at [p*DW +: DW] |
| rd_addr | input | NPORT*AW | Read addresses, port p at [p*AW +: AW] |
| rd_data | output | NPORT*DW | Read data, port p at [p*DW +: DW] |
| ok | output | NPORT | Per-port success flag for the previous cycle's write |
| fail | output | NPORT | Per-port fail flag for the previous cycle's write |

## Verification
The hardest situation to reach is the rotate policy with the turn pointer pointing at a port that is not in the clash group, so the scan has to wrap to find the winner. The pointer is not visible at the ports, so the stimulus first runs a known number of full four-port clashes in rotate mode, predicting the winner each time, which parks the pointer at the last port; a two-port clash on ports 1 and 2 then forces the wrapping scan, whose expected winner is port 1.

// File: rtl/wcr_pkg.sv
package wcr_pkg;
  typedef enum logic [1:0] {
    POL_AGREE  = 2'd0,
    POL_ROTATE = 2'd1,
    POL_RANK   = 2'd2,
    POL_ADD    = 2'd3
  } policy_e;
endpackage

// File: rtl/wcr_lane.sv
// Per-port clash analysis: finds the group of ports sharing this port's
// address and decides this port's grant and, when it leads the group, the commit.
module wcr_lane
  import wcr_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 3,
  parameter int DW    = 8,
  parameter int IDX   = 0,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  policy_e             pol,
  input  logic [NPORT-1:0]    vld,
  input  logic [NPORT*AW-1:0] addr,
  input  logic [NPORT*DW-1:0] data,
  input  logic [PW-1:0]       turn,
  output logic                commit_en,
  output logic [DW-1:0]       commit_val,
  output logic                grant,
  output logic                clash
);
  logic [NPORT-1:0] same;
  logic             agree, lead, found;
  logic [DW-1:0]    own, total, pick_val;
  int               pick, idx;

  always_comb begin
    own   = data[IDX*DW +: DW];
    same  = '0;
    agree = 1'b1;
    total = '0;
    lead  = vld[IDX];
    for (int j = 0; j < NPORT; j++) begin
      if (vld[j] && vld[IDX] && (addr[j*AW +: AW] == addr[IDX*AW +: AW])) begin
        same[j] = 1'b1;
        total   = total + data[j*DW +: DW];
        if (data[j*DW +: DW] != own) agree = 1'b0;
        if (j < IDX) lead = 1'b0;
      end
    end
    found = 1'b0;
    pick  = 0;
    idx   = 0;
    for (int k = 0; k < NPORT; k++) begin
      idx = (int'(turn) + k) % NPORT;
      if (!found && same[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
    pick_val = data[pick*DW +: DW];
  end

  assign clash = vld[IDX] && ($countones(same) > 1);

  always_comb begin
    grant      = 1'b0;
    commit_en  = 1'b0;
    commit_val = own;
    unique case (pol)
      POL_AGREE: begin
        grant     = vld[IDX] && agree;
        commit_en = lead && agree;
      end
      POL_ROTATE: begin
        grant      = vld[IDX] && (pick == IDX);
        commit_en  = lead;
        commit_val = pick_val;
      end
      POL_RANK: begin
        grant     = lead;
        commit_en = lead;
      end
      POL_ADD: begin
        grant      = vld[IDX];
        commit_en  = lead;
        commit_val = total;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/wcr_regfile.sv
// Register-file storage: one write per lane (addresses unique), NPORT reads.
module wcr_regfile #(
  parameter int NPORT = 4,
  parameter int AW    = 3,
  parameter int DW    = 8,
  localparam int DEPTH = 1 << AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NPORT-1:0]    we,
  input  logic [NPORT*AW-1:0] waddr,
  input  logic [NPORT*DW-1:0] wdata,
  input  logic [NPORT*AW-1:0] raddr,
  output logic [NPORT*DW-1:0] rdata
);
  logic [DW-1:0]    mem    [DEPTH];
  logic [DW-1:0]    mem_nx [DEPTH];
  logic [DEPTH-1:0] wen;

  always_comb begin
    wen = '0;
    for (int k = 0; k < DEPTH; k++) begin
      mem_nx[k] = mem[k];
      for (int p = 0; p < NPORT; p++) begin
        if (we[p] && (int'(waddr[p*AW +: AW]) == k)) begin
          wen[k]    = 1'b1;
          mem_nx[k] = wdata[p*DW +: DW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (wen[k]) mem[k] <= mem_nx[k];
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NPORT; p++) rdata[p*DW +: DW] = mem[raddr[p*AW +: AW]];
  end

  for (genvar a = 0; a < NPORT; a++) begin : g_pa
    for (genvar b = a + 1; b < NPORT; b++) begin : g_pb
      // R4
      unique_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we[a] && we[b] && (waddr[a*AW +: AW] == waddr[b*AW +: AW])));
    end
  end
endmodule

// File: rtl/wcr_resolver.sv
module wcr_resolver
  import wcr_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 3,
  parameter int DW    = 8,
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode,
  input  logic [NPORT-1:0]    wr_vld,
  input  logic [NPORT*AW-1:0] wr_addr,
  input  logic [NPORT*DW-1:0] wr_data,
  input  logic [NPORT*AW-1:0] rd_addr,
  output logic [NPORT*DW-1:0] rd_data,
  output logic [NPORT-1:0]    ok,
  output logic [NPORT-1:0]    fail
);
  policy_e          pol;
  logic [NPORT-1:0] grant, clash, cen;
  logic [NPORT*DW-1:0] cval;
  logic [PW-1:0]    turn_q, turn_nx;
  logic             turn_en;
  logic [NPORT-1:0] ok_nx, fail_nx;

  assign pol = policy_e'(mode);

  for (genvar i = 0; i < NPORT; i++) begin : g_lane
    wcr_lane #(.NPORT(NPORT), .AW(AW), .DW(DW), .IDX(i)) i_lane (
      .pol        (pol),
      .vld        (wr_vld),
      .addr       (wr_addr),
      .data       (wr_data),
      .turn       (turn_q),
      .commit_en  (cen[i]),
      .commit_val (cval[i*DW +: DW]),
      .grant      (grant[i]),
      .clash      (clash[i])
    );
  end

  wcr_regfile #(.NPORT(NPORT), .AW(AW), .DW(DW)) i_regfile (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cen),
    .waddr (wr_addr),
    .wdata (cval),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  // next-state
  always_comb begin
    turn_en = (pol == POL_ROTATE) && (|clash);
    turn_nx = (int'(turn_q) == NPORT - 1) ? '0 : turn_q + 1'b1;
    ok_nx   = grant;
    fail_nx = wr_vld & ~grant;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      turn_q <= '0;
      ok     <= '0;
      fail   <= '0;
    end else begin
      if (turn_en) turn_q <= turn_nx;
      ok   <= ok_nx;
      fail <= fail_nx;
    end
  end

  // R3
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ok & fail) == '0);

  for (genvar i = 0; i < NPORT; i++) begin : g_chk
    // R3
    idle_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_vld[i]) |-> !(ok[i] || fail[i]));
  end

  // R6
  turn_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (turn_q != $past(turn_q)) |->
      (turn_q == ((int'($past(turn_q)) == NPORT - 1) ? PW'(0) : PW'($past(turn_q) + 1'b1))));

  // R7
  rank_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd2 && $past(wr_vld[0])) |-> ok[0]);

  // R8
  add_all_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'd3) |-> (ok == $past(wr_vld)));
endmodule

// File: tb/test_wcr_resolver.sv
`timescale 1ns/1ps
module test_wcr_resolver;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int DW = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [1:0]      mode;
  logic [N-1:0]    wr_vld;
  logic [N*AW-1:0] wr_addr;
  logic [N*DW-1:0] wr_data;
  logic [N*AW-1:0] rd_addr;
  logic [N*DW-1:0] rd_data;
  logic [N-1:0]    ok, fail;

  always #5 clk = ~clk;

  wcr_resolver #(.NPORT(N), .AW(AW), .DW(DW)) i_wcr_resolver (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .ok(ok), .fail(fail));

  typedef struct { logic [N-1:0] ok; logic [N-1:0] fail; string tag; } item_t;
  item_t q[$];

  int checks = 0, errors = 0, bturn = 0;
  logic [DW-1:0] mdl [8];
  bit done = 0;

  task automatic check(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: computes expected flags and memory from the requirements
  task automatic req(input int md, input logic [N-1:0] v, input logic [N*AW-1:0] a,
                     input logic [N*DW-1:0] d, input string tag);
    item_t it;
    bit any_clash = 0;
    @(negedge clk);
    mode = 2'(md); wr_vld = v; wr_addr = a; wr_data = d;
    it.ok = '0; it.fail = '0; it.tag = tag;
    for (int i = 0; i < N; i++) begin
      bit first = 1, agree = 1;
      int cnt = 0, win = -1;
      logic [DW-1:0] sum = '0;
      logic [DW-1:0] val;
      if (!v[i]) continue;
      for (int j = 0; j < N; j++) begin
        if (v[j] && a[j*AW +: AW] == a[i*AW +: AW]) begin
          cnt++;
          sum += d[j*DW +: DW];
          if (d[j*DW +: DW] != d[i*DW +: DW]) agree = 0;
          if (j < i) first = 0;
        end
      end
      for (int k = 0; k < N; k++) begin
        int p = (bturn + k) % N;
        if (win < 0 && v[p] && a[p*AW +: AW] == a[i*AW +: AW]) win = p;
      end
      if (cnt > 1) any_clash = 1;
      case (md)
        0: begin it.ok[i] = agree; val = d[i*DW +: DW]; if (first && agree) mdl[a[i*AW +: AW]] = val; end
        1: begin it.ok[i] = (win == i); if (first) mdl[a[i*AW +: AW]] = d[win*DW +: DW]; end
        2: begin it.ok[i] = first; if (first) mdl[a[i*AW +: AW]] = d[i*DW +: DW]; end
        default: begin it.ok[i] = 1; if (first) mdl[a[i*AW +: AW]] = sum; end
      endcase
      it.fail[i] = !it.ok[i];
    end
    if (md == 1 && any_clash) bturn = (bturn + 1) % N;
    q.push_back(it);
  endtask

  // idle cycle with concurrent reads of four addresses, checked against the model
  task automatic rd_chk(input logic [N*AW-1:0] ra, input string tag);
    item_t it;
    @(negedge clk);
    wr_vld = '0; wr_data = '1; wr_addr = '1;
    it.ok = '0; it.fail = '0; it.tag = {tag, " R3 idle"};
    q.push_back(it);
    rd_addr = ra;
    #1;
    for (int p = 0; p < N; p++)
      check(rd_data[p*DW +: DW] === mdl[ra[p*AW +: AW]], {tag, " R2 read"},
            32'(rd_data[p*DW +: DW]), 32'(mdl[ra[p*AW +: AW]]));
  endtask

  // monitor: compares flags one edge after each request
  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(ok === it.ok,   {it.tag, " ok"},   32'(ok),   32'(it.ok));
      check(fail === it.fail, {it.tag, " fail"}, 32'(fail), 32'(it.fail));
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    rst_n = 0; mode = 0; wr_vld = '0; wr_addr = '0; wr_data = '0;
    rd_addr = {3'd7, 3'd5, 3'd2, 3'd0};
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(ok === '0 && fail === '0, "R1 flags in reset", 32'({ok, fail}), 0);
    for (int p = 0; p < N; p++)
      check(rd_data[p*DW +: DW] === '0, "R1 memory in reset", 32'(rd_data[p*DW +: DW]), 0);
    @(negedge clk);
    rst_n = 1;
    rd_chk({3'd6, 3'd4, 3'd3, 3'd1}, "R1 after reset");

    // R4 distinct addresses, all commit
    req(2, 4'b1111, {3'd3, 3'd2, 3'd1, 3'd0}, {8'h44, 8'h33, 8'h22, 8'h11}, "R4 distinct");
    rd_chk({3'd3, 3'd2, 3'd1, 3'd0}, "R4 readback");

    // R5 agree, port 3 invalid with other data (R9)
    req(0, 4'b0111, {3'd4, 3'd4, 3'd4, 3'd4}, {8'h99, 8'h55, 8'h55, 8'h55}, "R5 agree R9");
    rd_chk({3'd4, 3'd4, 3'd4, 3'd4}, "R5 agree same-addr");
    req(0, 4'b0011, {3'd4, 3'd4, 3'd4, 3'd4}, {8'h00, 8'h00, 8'h67, 8'h66}, "R5 disagree");
    rd_chk({3'd4, 3'd4, 3'd4, 3'd4}, "R5 old value kept");

    // R7 rank
    req(2, 4'b1110, {3'd5, 3'd5, 3'd5, 3'd5}, {8'hA3, 8'hA2, 8'hA1, 8'hA0}, "R7 rank");
    rd_chk({3'd5, 3'd5, 3'd5, 3'd5}, "R7 readback");

    // R6 rotate: three full clashes, then a wrapping scan
    for (int r = 0; r < 3; r++) begin
      req(1, 4'b1111, {3'd6, 3'd6, 3'd6, 3'd6}, {8'h40, 8'h30, 8'h20, 8'h10 + 8'(r)}, "R6 rotate");
      rd_chk({3'd6, 3'd6, 3'd6, 3'd6}, "R6 readback");
    end
    req(1, 4'b0110, {3'd0, 3'd0, 3'd0, 3'd0}, {8'hD3, 8'hD2, 8'hD1, 8'hD0}, "R6 wrap scan");
    rd_chk({3'd0, 3'd0, 3'd0, 3'd0}, "R6 wrap readback");

    // R8 add with wrap: 80+90+10+05 = 0x25 mod 256
    req(3, 4'b1111, {3'd7, 3'd7, 3'd7, 3'd7}, {8'h05, 8'h10, 8'h90, 8'h80}, "R8 add");
    rd_chk({3'd7, 3'd7, 3'd7, 3'd7}, "R8 readback");

    // R4 two independent clash groups under rank
    req(2, 4'b1111, {3'd2, 3'd1, 3'd2, 3'd1}, {8'hB3, 8'hB2, 8'hB1, 8'hB0}, "R4 two groups");
    rd_chk({3'd2, 3'd1, 3'd2, 3'd1}, "R4 groups readback");

    // R9 no valid ports: nothing written
    req(3, 4'b0000, {3'd3, 3'd3, 3'd3, 3'd3}, {8'hFF, 8'hFF, 8'hFF, 8'hFF}, "R9 no valid");
    rd_chk({3'd3, 3'd3, 3'd3, 3'd3}, "R9 readback");

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule